// File: doc/BRIEF.md
# Load/Store Address and Byte-Serial Memory Unit

This block serves the load and store instructions of a small load/store processor. Each request carries an opcode, a destination or source register index, a base register index, a 17-bit signed displacement, the current program counter and the value of the base register. From these the block forms a 32-bit effective address in one of two ways. PC-relative operations add the displacement to the program counter. Displacement operations add it to a base register. A base index of zero in the displacement form means "no base", not register zero.

Loads and stores move one 32-bit word through a memory built from 8-bit cells. The block uses four byte transfers on a request/ready handshake, most significant byte at the lowest address. Load-address operations return the computed address and never touch memory. The register file and instruction fetch sit outside. The block returns a write-back (index, data, enable) and a one-cycle completion pulse.

Top module: `lsu_top`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it, busy, mem_req, mem_we, done and wb_en are all 0.
- R2: For opcodes 1 (word load), 3 (word store) and 5 (address load), the address is the sign-extended displacement when rb_idx is 0. Otherwise it is base_val plus the sign-extended displacement.
- R3: For opcodes 2 (load), 4 (store) and 6 (address load), the address is pc_val plus the sign-extended displacement, and base_val and rb_idx have no effect.
- R4: Displacement bit 16 is the sign bit. A displacement of 0x1FFFC subtracts 4, and 0x10000 subtracts 65536.
- R5: For opcodes 5 and 6 the block accepts start and raises done and wb_en in the next cycle, with wb_data equal to the address and wb_idx equal to ra_idx. It issues no memory request.
- R6: For opcodes 1 and 2 the block reads addresses A, A+1, A+2, A+3 in that order. The byte from A lands in wb_data[31:24] and the byte from A+3 lands in wb_data[7:0]. The word is written back to ra_idx.
- R7: For opcodes 3 and 4 the block writes store_data to A..A+3 with mem_we high, bits 31:24 first at A, and raises no wb_en.
- R8: A byte transfer completes only in a cycle where mem_req and mem_ready are both high. Until then mem_req, mem_we, mem_addr and mem_wdata hold their values.
- R9: done is high for exactly one cycle, the cycle after the fourth completed byte transfer.
- R10: start is ignored while busy is high. Opcodes other than 1 to 6 are ignored: no request, no done, busy stays 0.
- R11: The byte addresses A+1..A+3 wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled when idle |
| opcode | input | 5 | Operation code (1 to 6 accepted) |
| ra_idx | input | 5 | Destination register index for loads |
| rb_idx | input | 5 | Base register index, 0 means no base |
| disp | input | 17 | Signed displacement |
| pc_val | input | 32 | Program counter value |
| base_val | input | 32 | Contents of register rb_idx |
| store_data | input | 32 | Word to store (contents of register ra) |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Byte transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read from memory |
| mem_ready | input | 1 | Memory completes the current byte |
| wb_en | output | 1 | Register write-back enable |
| wb_idx | output | 5 | Register write-back index |
| wb_data | output | 32 | Register write-back value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The in-RTL assertions check the following every cycle:
- the request is held stable through wait states;
- the byte address steps by one after each completed transfer, wrapping as needed;
- done lasts one cycle, follows the last transfer, and never coincides with a request;
- reset returns the unit to idle.

Only the bench's scenarios can show the rest:
- the address arithmetic for each addressing form and sign case;
- the big-endian placement of bytes on loads and stores;
- stores that are read back by later loads;
- starts and invalid opcodes being ignored.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int LSU_ADDR_W = 32;
    localparam int LSU_BYTE_W = 8;
    localparam int LSU_DISP_W = 17;
    localparam int LSU_IDX_W  = 5;
    localparam int LSU_OP_W   = 5;

    // Opcode values the unit accepts
    localparam logic [LSU_OP_W-1:0] OPC_LD  = 5'd1;
    localparam logic [LSU_OP_W-1:0] OPC_LDR = 5'd2;
    localparam logic [LSU_OP_W-1:0] OPC_ST  = 5'd3;
    localparam logic [LSU_OP_W-1:0] OPC_STR = 5'd4;
    localparam logic [LSU_OP_W-1:0] OPC_LA  = 5'd5;
    localparam logic [LSU_OP_W-1:0] OPC_LAR = 5'd6;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_LOAD,
        KIND_STORE,
        KIND_ADDR
    } xfer_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_FIN
    } lsu_state_e;

    typedef struct packed {
        xfer_kind_e kind;
        logic       pc_rel;
    } op_dec_t;

    function automatic op_dec_t decode_op(input logic [LSU_OP_W-1:0] opc);
        op_dec_t d;
        d.kind   = KIND_NONE;
        d.pc_rel = 1'b0;
        case (opc)
            OPC_LD:  d.kind = KIND_LOAD;
            OPC_ST:  d.kind = KIND_STORE;
            OPC_LA:  d.kind = KIND_ADDR;
            OPC_LDR: begin d.kind = KIND_LOAD;  d.pc_rel = 1'b1; end
            OPC_STR: begin d.kind = KIND_STORE; d.pc_rel = 1'b1; end
            OPC_LAR: begin d.kind = KIND_ADDR;  d.pc_rel = 1'b1; end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lsu_agen.sv
// Effective address: origin (PC, base register or zero) plus sign-extended displacement.
module lsu_agen #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 17
) (
    input  logic              pc_rel,
    input  logic              base_none,
    input  logic [ADDR_W-1:0] pc_val,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] ea
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] origin;

    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        if (pc_rel)
            origin = pc_val;
        else if (base_none)
            origin = '0;
        else
            origin = base_val;
        ea = origin + disp_ext;
    end
endmodule

// File: rtl/lsu_ctrl.sv
// Sequencer: idle, byte transfers counted by cnt, one finishing cycle.
module lsu_ctrl
    import lsu_pkg::*;
#(
    parameter  int NBYTES = 4,
    localparam int CNT_W  = $clog2(NBYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             addr_only,
    input  logic             mem_ready,
    output lsu_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic             step
);
    logic last;

    always_comb begin
        step = (state == ST_XFER) && mem_ready;
        last = (cnt == CNT_W'(NBYTES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (launch) begin
                    cnt   <= '0;
                    state <= addr_only ? ST_FIN : ST_XFER;
                end
                ST_XFER: if (step) begin
                    cnt <= cnt + 1'b1;
                    if (last) state <= ST_FIN;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: reset leaves the sequencer idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> state == ST_IDLE);

    // R9: completion follows the final byte
    a_r9_fin_after_last: assert property (@(posedge clk) disable iff (rst)
        step && last |=> state == ST_FIN);

    // R9: completion lasts a single cycle
    a_r9_fin_one_cycle: assert property (@(posedge clk) disable iff (rst)
        state == ST_FIN |=> state != ST_FIN);

    // R8: no progress without ready
    a_r8_wait_no_advance: assert property (@(posedge clk) disable iff (rst)
        state == ST_XFER && !mem_ready |=> state == ST_XFER && $stable(cnt));
endmodule

// File: rtl/lsu_pack.sv
// Shared word register: shifts left one byte per transfer.
// On a store the top byte is the next one out; on a load bytes enter at the bottom.
module lsu_pack #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [DATA_W-1:0] word,
    output logic [BYTE_W-1:0] head
);
    always_ff @(posedge clk) begin
        if (rst)
            word <= '0;
        else if (load)
            word <= load_val;
        else if (shift)
            word <= {word[DATA_W-BYTE_W-1:0], byte_in};
    end

    assign head = word[DATA_W-1 -: BYTE_W];
endmodule

// File: rtl/lsu_top.sv
module lsu_top
    import lsu_pkg::*;
#(
    parameter int ADDR_W = LSU_ADDR_W,
    parameter int DISP_W = LSU_DISP_W,
    parameter int IDX_W  = LSU_IDX_W,
    parameter int OP_W   = LSU_OP_W,
    parameter int BYTE_W = LSU_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   opcode,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] pc_val,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] store_data,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [ADDR_W-1:0] wb_data,
    output logic              done
);
    localparam int NBYTES = ADDR_W / BYTE_W;
    localparam int CNT_W  = $clog2(NBYTES);

    op_dec_t           dec;
    logic              launch;
    logic [ADDR_W-1:0] ea;
    logic [ADDR_W-1:0] pack_init;
    lsu_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic              step;
    logic [ADDR_W-1:0] word;
    logic [BYTE_W-1:0] head;

    xfer_kind_e        kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  dst_q;

    always_comb begin
        dec       = decode_op(opcode);
        launch    = start && (state == ST_IDLE) && (dec.kind != KIND_NONE);
        pack_init = (dec.kind == KIND_STORE) ? store_data : ea;
    end

    lsu_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
        .pc_rel   (dec.pc_rel),
        .base_none(rb_idx == '0),
        .pc_val   (pc_val),
        .base_val (base_val),
        .disp     (disp),
        .ea       (ea)
    );

    lsu_ctrl #(.NBYTES(NBYTES)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .addr_only(dec.kind == KIND_ADDR),
        .mem_ready(mem_ready),
        .state    (state),
        .cnt      (cnt),
        .step     (step)
    );

    lsu_pack #(.DATA_W(ADDR_W), .BYTE_W(BYTE_W)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .load    (launch),
        .load_val(pack_init),
        .shift   (step),
        .byte_in (mem_rdata),
        .word    (word),
        .head    (head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= KIND_NONE;
            addr_q <= '0;
            dst_q  <= '0;
        end else if (launch) begin
            kind_q <= dec.kind;
            addr_q <= ea;
            dst_q  <= ra_idx;
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        mem_req   = (state == ST_XFER);
        mem_we    = mem_req && (kind_q == KIND_STORE);
        mem_addr  = addr_q + ADDR_W'(cnt);
        mem_wdata = head;
        done      = (state == ST_FIN);
        wb_en     = done && (kind_q != KIND_STORE);
        wb_idx    = dst_q;
        wb_data   = word;
    end

    // R8: an unanswered request keeps its address, direction and data
    a_r8_hold_request: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_wdata));

    // R11: after a completed byte the next address is one higher (mod 2^32)
    a_r11_addr_step: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ready |=> !mem_req || (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R5: completion never overlaps a memory access
    a_r5_done_no_access: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req && !mem_we);

    // R7: write strobe only inside a request
    a_r7_we_in_req: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);
endmodule

// File: tb/lsu_top_tb.sv
`timescale 1ns/1ps
module lsu_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  opcode = '0, ra_idx = '0, rb_idx = '0;
    logic [16:0] disp = '0;
    logic [31:0] pc_val = '0, base_val = '0, store_data = '0;
    logic        busy, mem_req, mem_we, wb_en, done;
    logic [31:0] mem_addr, wb_data;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [4:0]  wb_idx;

    always #2.5 clk = ~clk;

    lsu_top u_dut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .ra_idx(ra_idx),
        .rb_idx(rb_idx), .disp(disp), .pc_val(pc_val), .base_val(base_val),
        .store_data(store_data), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .done(done)
    );

    typedef struct packed {
        logic [4:0]  opc;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [16:0] dsp;
        logic [31:0] pc;
        logic [31:0] base;
        logic [31:0] sdata;
    } item_t;

    item_t q[$];
    string tq[$];
    logic [7:0] mem [logic [31:0]];

    int n_chk = 0;
    int n_fail = 0;

    // reference state
    int          ph = 0;      // 0 idle, 1 transferring, 2 finishing
    int          mk = 0;      // 1 load, 2 store, 3 address
    int          mc = 0;
    logic [31:0] ma = '0, mexp = '0, msd = '0;
    logic [4:0]  mra = '0;
    string       ctx = "R1";
    logic [15:0] lf = 16'hACE1;

    function automatic logic [7:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic add(input int opc, input int ra, input int rb, input int dsp,
                       input logic [31:0] pc, input logic [31:0] base,
                       input logic [31:0] sd, input string tag);
        item_t it;
        it.opc = 5'(opc); it.ra = 5'(ra); it.rb = 5'(rb); it.dsp = 17'(dsp);
        it.pc = pc; it.base = base; it.sdata = sd;
        q.push_back(it);
        tq.push_back(tag);
    endtask

    initial begin
        int cyc;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "busy", {31'b0, busy}, 0);
        chk("R1", "mem_req", {31'b0, mem_req}, 0);
        chk("R1", "mem_we", {31'b0, mem_we}, 0);
        chk("R1", "done", {31'b0, done}, 0);
        chk("R1", "wb_en", {31'b0, wb_en}, 0);
        rst = 1'b0;

        add(5, 3, 0, 'h00123, 32'h0, 32'hDEAD0000, 0, "R2 R5 la-nobase");
        add(5, 4, 3, 'h1FFFC, 32'h0, 32'h00001000, 0, "R2 R4 la-base-neg");
        add(6, 7, 9, 'h00038, 32'h00000400, 32'h77777777, 0, "R3 R5 lar");
        add(3, 8, 0, 'h000D0, 32'h0, 32'hFFFF0000, 32'h11223344, "R2 R7 st");
        add(1, 9, 0, 'h000D0, 32'h0, 32'h12345678, 0, "R2 R6 ld-readback");
        add(4, 1, 6, 'h00010, 32'h00000200, 32'h0BAD0BAD, 32'hCAFEBABE, "R3 R7 str");
        add(2, 2, 6, 'h00010, 32'h00000200, 32'h0F0F0F0F, 0, "R3 R6 ldr");
        add(1, 10, 5, 'h10000, 32'h0, 32'h00008000, 0, "R2 R4 ld-neg");
        add(0, 1, 1, 'h00004, 32'h0, 32'h0, 0, "R10 opc0");
        add(7, 1, 1, 'h00004, 32'h0, 32'h0, 0, "R10 opc7");
        add(31, 1, 1, 'h00004, 32'h0, 32'h0, 0, "R10 opc31");
        add(1, 11, 2, 'h00000, 32'h0, 32'hFFFFFFFE, 0, "R11 ld-wrap");
        add(3, 12, 2, 'h00000, 32'h0, 32'hFFFFFFFD, 32'hA1B2C3D4, "R11 R7 st-wrap");
        add(1, 13, 2, 'h00000, 32'h0, 32'hFFFFFFFD, 0, "R11 R6 ld-wrap-back");
        add(1, 14, 4, 'h00100, 32'h0, 32'h00ABC000, 0, "R6 R10 ld-busy-start");

        cyc = 0;
        while ((q.size() > 0 || ph != 0) && cyc < 20000) begin
            logic [31:0] a;
            logic        take;
            // compare outputs against the reference
            chk({ctx, " R8"}, "busy", {31'b0, busy}, {31'b0, ph != 0});
            chk({ctx, " R8"}, "mem_req", {31'b0, mem_req}, {31'b0, ph == 1});
            chk({ctx, " R7"}, "mem_we", {31'b0, mem_we}, {31'b0, ph == 1 && mk == 2});
            chk({ctx, " R9"}, "done", {31'b0, done}, {31'b0, ph == 2});
            chk({ctx, " R5"}, "wb_en", {31'b0, wb_en}, {31'b0, ph == 2 && mk != 2});
            if (ph == 1) begin
                chk({ctx, " R11"}, "mem_addr", mem_addr, ma + 32'(mc));
                if (mk == 2)
                    chk({ctx, " R7"}, "mem_wdata", {24'b0, mem_wdata},
                        {24'b0, 8'(msd >> (8 * (3 - mc)))});
            end
            if (ph == 2 && mk != 2) begin
                chk({ctx, " R6"}, "wb_data", wb_data, mexp);
                chk({ctx, " R6"}, "wb_idx", {27'b0, wb_idx}, {27'b0, mra});
            end

            // drive the next cycle
            start = 1'b0;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            mem_ready = lf[0];
            mem_rdata = rd(mem_addr);
            if (ph == 0 && q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                ctx = tq.pop_front();
                start = 1'b1; opcode = it.opc; ra_idx = it.ra; rb_idx = it.rb;
                disp = it.dsp; pc_val = it.pc; base_val = it.base; store_data = it.sdata;
            end else if (ph != 0 && (cyc % 3 == 1)) begin
                // R10: starts while busy must change nothing
                start = 1'b1; opcode = 5'd3; ra_idx = 5'd31; rb_idx = 5'd1;
                disp = 17'h00055; pc_val = 32'h13579BDF; base_val = {lf, lf};
                store_data = 32'hEEEEEEEE;
            end

            // advance the reference by one clock
            take = start && opcode >= 1 && opcode <= 6;
            case (ph)
                0: if (take) begin
                    a = {{15{disp[16]}}, disp};
                    if (opcode == 2 || opcode == 4 || opcode == 6) a = a + pc_val;
                    else if (rb_idx != 0) a = a + base_val;
                    ma = a; mc = 0; mra = ra_idx; msd = store_data;
                    if (opcode == 5 || opcode == 6) begin
                        mk = 3; mexp = a; ph = 2;
                    end else if (opcode == 3 || opcode == 4) begin
                        mk = 2; ph = 1;
                    end else begin
                        mk = 1; ph = 1;
                        mexp = {rd(a), rd(a + 1), rd(a + 2), rd(a + 3)};
                    end
                end
                1: if (mem_ready) begin
                    if (mk == 2) mem[ma + 32'(mc)] = 8'(msd >> (8 * (3 - mc)));
                    mc++;
                    if (mc == 4) ph = 2;
                end
                default: ph = 0;
            endcase

            @(negedge clk);
            cyc++;
        end

        // R10: after the ignored opcodes and the final word, the unit is quiet
        repeat (2) begin
            start = 1'b0;
            @(negedge clk);
            chk("R10", "busy", {31'b0, busy}, 0);
            chk("R9", "done", {31'b0, done}, 0);
        end

        if (cyc >= 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule